// File: doc/BRIEF.md
# Four-Lane 7:1 Pixel Serializer

The block takes a 28-bit pixel word on every pixel clock and cuts it into four 7-bit slices. Each slice leaves on its own serial data lane at seven bits per pixel period, clocked by a bit clock that runs at exactly seven times the pixel rate and is phase-aligned to it. A fifth lane sends a fixed 7-bit pattern in every pixel period. This lets a receiver recover the pixel frequency and find where each frame of seven bits begins.

A select input chooses whether words are captured on the rising or the falling edge of the pixel clock. Captured words cross into the bit-clock domain through a toggle handshake. The toggle is synchronized into the bit-clock domain, and a 3-bit count (0 to 6) in that domain then fixes the slot in which every new word enters the shift registers. The count locks to the arrival of the first word after enable and then runs freely. While the enable is low, nothing is captured or shifted and all five lanes are held low.

Top module: `pix_serializer`

## Requirements
- R1: With `edge_sel` = 0 words are captured on rising edges of `pix_clk`; with `edge_sel` = 1 they are captured on falling edges. A capture happens only when `enable` is high at that edge.
- R2: Lane n (n = 0..3) of `lane_dout` carries word bits 7n to 7n+6, with the lowest-index bit sent first and one bit per `bit_clk` cycle.
- R3: In every pixel period `lane_clk` sends 1,1,0,0,0,1,1 in time order, which gives exactly one rising and one falling transition per period.
- R4: Bit 0 of each slice leaves in the same `bit_clk` cycle as the first 1 of the clock-lane pattern.
- R5: Within 4 `bit_clk` cycles after `enable` falls, all five lane outputs are low, and they stay low while `enable` stays low. Words presented while disabled are never sent.
- R6: After `enable` rises, the first frame on the lanes carries the first word captured with `enable` high. Later frames carry the later captured words in order, and no word is dropped.
- R7: While `rst_n` is low, and after reset until the first word is loaded, all lane outputs are low.
- R8: The 7-count locks to the first word arrival after enable. It then issues a parallel load every seven `bit_clk` cycles, and each load coincides with the arrival of a new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel clock, one word per period |
| bit_clk | input | 1 | Serial bit clock, 7x `pix_clk`, phase-aligned |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| edge_sel | input | 1 | Capture edge: 0 rising, 1 falling |
| enable | input | 1 | High to capture and serialize, low to hold all lanes low |
| pix_data | input | 28 | Parallel pixel word |
| lane_dout | output | 4 | Serial data lanes, lane n carries slice n |
| lane_clk | output | 1 | Clock-lane pattern output |

## Verification
The load-slot assertion relies on `bit_clk` running at exactly seven times `pix_clk`, so that every synchronized word arrival falls on the last count value. The bench derives both clocks from one time base with the pixel edges offset from the bit edges, which keeps that assumption true. The capture-edge assertions and the single-word mux rely on `edge_sel` changing only while the block is disabled. They also rely on `pix_data` and `enable` never changing at a capture edge. The stimulus changes data on the edge opposite the selected one, raises and drops `enable` at fixed offsets clear of both pixel edges, and switches `edge_sel` only between bursts.

// File: rtl/pxser_pkg.sv
package pxser_pkg;
   parameter int unsigned DEF_LANES   = 4;
   parameter int unsigned DEF_SLICE   = 7;
   parameter int unsigned DEF_SYNC    = 2;
   // Clock-lane pattern, bit 0 leaves first: 1,1,0,0,0,1,1
   parameter logic [6:0]  DEF_CLK_PAT = 7'b1100011;
endpackage

// File: rtl/pxser_sync.sv
module pxser_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pxser_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pxser_capture.sv
module pxser_capture #(
   parameter int unsigned WORD_W = 28
) (
   input  logic              pix_clk,
   input  logic              rst_n,
   input  logic              edge_sel,
   input  logic              enable,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] word,
   output logic              tgl
);
   logic [WORD_W-1:0] word_p, word_n;
   logic              tgl_p, tgl_n;

   // rising-edge capture path
   always_ff @(posedge pix_clk or negedge rst_n) begin
      if (!rst_n) begin
         word_p <= '0;
         tgl_p  <= 1'b0;
      end else if (enable && !edge_sel) begin
         word_p <= din;
         tgl_p  <= ~tgl_p;
      end
   end

   // falling-edge capture path
   always_ff @(negedge pix_clk or negedge rst_n) begin
      if (!rst_n) begin
         word_n <= '0;
         tgl_n  <= 1'b0;
      end else if (enable && edge_sel) begin
         word_n <= din;
         tgl_n  <= ~tgl_n;
      end
   end

   assign word = edge_sel ? word_n : word_p;
   // only one of the two toggles moves for a given edge_sel, so the xor is glitch free
   assign tgl  = tgl_p ^ tgl_n;

   p_rise_idle_r1: assert property (@(posedge pix_clk) disable iff (!rst_n)
      (edge_sel || !enable) |=> $stable(tgl_p));
   p_fall_idle_r1: assert property (@(negedge pix_clk) disable iff (!rst_n)
      (!edge_sel || !enable) |=> $stable(tgl_n));
endmodule

// File: rtl/pxser_lane.sv
module pxser_lane #(
   parameter int unsigned SLICE = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [SLICE-1:0] par,
   output logic             sout
);
   logic [SLICE-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr <= '0;
      else if (clear) sr <= '0;
      else if (load)  sr <= par;
      else            sr <= {1'b0, sr[SLICE-1:1]};
   end

   assign sout = sr[0];
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
   import pxser_pkg::*;
#(
   parameter int unsigned      LANES       = DEF_LANES,
   parameter int unsigned      SLICE       = DEF_SLICE,
   parameter int unsigned      SYNC_STAGES = DEF_SYNC,
   parameter logic [SLICE-1:0] CLK_PAT     = DEF_CLK_PAT,
   localparam int unsigned     WORD_W      = LANES * SLICE,
   localparam int unsigned     CNT_W       = $clog2(SLICE)
) (
   input  logic              pix_clk,
   input  logic              bit_clk,
   input  logic              rst_n,
   input  logic              edge_sel,
   input  logic              enable,
   input  logic [WORD_W-1:0] pix_data,
   output logic [LANES-1:0]  lane_dout,
   output logic              lane_clk
);
   if (SLICE < 2) begin : g_bad_slice
      $error("pix_serializer: SLICE must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("pix_serializer: LANES must be at least 1");
   end

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLICE - 1);

   logic [WORD_W-1:0] cap_word;
   logic              cap_tgl, tgl_s, tgl_d, pulse;
   logic              en_b, clr, locked, load;
   logic [CNT_W-1:0]  cnt;

   pxser_capture #(.WORD_W(WORD_W)) i_capture (
      .pix_clk (pix_clk),
      .rst_n   (rst_n),
      .edge_sel(edge_sel),
      .enable  (enable),
      .din     (pix_data),
      .word    (cap_word),
      .tgl     (cap_tgl)
   );

   pxser_sync #(.W(1), .STAGES(SYNC_STAGES)) i_sync_tgl (
      .clk(bit_clk), .rst_n(rst_n), .d(cap_tgl), .q(tgl_s)
   );
   pxser_sync #(.W(1), .STAGES(SYNC_STAGES)) i_sync_en (
      .clk(bit_clk), .rst_n(rst_n), .d(enable), .q(en_b)
   );

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) tgl_d <= 1'b0;
      else        tgl_d <= tgl_s;
   end

   assign pulse = tgl_s ^ tgl_d;
   assign clr   = ~en_b;
   // before lock the first arrival sets the slot, afterwards the count does
   assign load  = en_b && (locked ? (cnt == CNT_LAST) : pulse);

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         locked <= 1'b0;
      end else if (!en_b) begin
         cnt    <= '0;
         locked <= 1'b0;
      end else if (load) begin
         cnt    <= '0;
         locked <= 1'b1;
      end else if (locked) begin
         cnt    <= cnt + CNT_W'(1);
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      pxser_lane #(.SLICE(SLICE)) i_lane (
         .clk  (bit_clk),
         .rst_n(rst_n),
         .clear(clr),
         .load (load),
         .par  (cap_word[g*SLICE +: SLICE]),
         .sout (lane_dout[g])
      );
   end

   pxser_lane #(.SLICE(SLICE)) i_clk_lane (
      .clk  (bit_clk),
      .rst_n(rst_n),
      .clear(clr),
      .load (load),
      .par  (CLK_PAT),
      .sout (lane_clk)
   );

   p_load_aligned_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (en_b && locked && pulse) |-> (cnt == CNT_LAST));
   p_cnt_range_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
      cnt <= CNT_LAST);
   p_disabled_low_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !en_b |=> (lane_dout == '0 && !lane_clk));
   p_clk_rise_slot_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
      $rose(lane_clk) |-> (cnt == CNT_W'(5) || cnt == '0));
endmodule

// File: tb/test_pix_serializer.sv
`timescale 1ns/100ps
module test_pix_serializer;
   localparam int LANES = 4;
   localparam int SLICE = 7;
   localparam int W     = LANES * SLICE;
   localparam int NF    = 30;

   logic         bit_clk = 1'b0, pix_clk = 1'b0;
   logic         rst_n = 1'b0, edge_sel = 1'b0, enable = 1'b0;
   logic [W-1:0] pix_data = '0;
   logic [LANES-1:0] lane_dout;
   logic             lane_clk;

   int nchk = 0, nfail = 0;
   int wr_idx = 0, rd_idx = 0;
   bit mon_on = 1'b0;
   logic [W-1:0] exp_q [0:511];

   pix_serializer i_pix_serializer (
      .pix_clk(pix_clk), .bit_clk(bit_clk), .rst_n(rst_n), .edge_sel(edge_sel),
      .enable(enable), .pix_data(pix_data), .lane_dout(lane_dout), .lane_clk(lane_clk)
   );

   always #2.5 bit_clk = ~bit_clk;
   initial begin
      #1;
      forever begin pix_clk = 1'b1; #15; pix_clk = 1'b0; #20; end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // R1: expected capture on the selected edge while enable is high
   always @(posedge pix_clk) if (rst_n && enable && !edge_sel) begin
      exp_q[wr_idx % 512] = pix_data; wr_idx++;
   end
   always @(negedge pix_clk) if (rst_n && enable && edge_sel) begin
      exp_q[wr_idx % 512] = pix_data; wr_idx++;
   end

   // frame decoder: lanes are low until the first load, so the first 1 on lane_clk is slot 0
   int st = 0, idx = 0;
   logic [W-1:0]     acc;
   logic [SLICE-1:0] cacc;
   always @(negedge bit_clk) begin
      if (!mon_on) st = 0;
      else begin
         if (st == 0 && lane_clk) begin st = 1; idx = 0; end
         if (st == 1) begin
            for (int l = 0; l < LANES; l++) acc[l*SLICE + idx] = lane_dout[l];
            cacc[idx] = lane_clk;
            idx++;
            if (idx == SLICE) begin
               idx = 0;
               chk("R3 clock-lane pattern", 32'(cacc), 32'(7'b1100011));
               if (rd_idx < wr_idx)
                  chk(edge_sel ? "R1 fall R2 R4 R6 word" : "R1 rise R2 R4 R6 word",
                      32'(acc), 32'(exp_q[rd_idx % 512]));
               else
                  chk("R6 frame without capture", 32'(acc), 32'hDEAD);
               rd_idx++;
            end
         end
      end
   end

   function automatic logic [W-1:0] gen(input int kind, input int i);
      logic [31:0] v;
      case (kind)
         0: v = 32'(1) << (i % W);
         1: v = ~(32'(1) << (i % W));
         2: v = (i[0] ? 32'h5555555 : 32'hAAAAAAA) ^ 32'(i * 3);
         default: v = (32'(i) * 32'h9E3779B1) ^ (32'(i) << 13);
      endcase
      return v[W-1:0];
   endfunction

   task automatic run_burst(input int b);
      int offs [8] = '{3, 7, 11, 19, 24, 29, 5, 22};
      edge_sel = b[0];
      wr_idx = 0; rd_idx = 0;
      @(posedge pix_clk); #(offs[b]);
      mon_on = 1'b1; enable = 1'b1;
      for (int i = 0; i < NF; i++) begin
         if (edge_sel) @(posedge pix_clk); else @(negedge pix_clk);
         #1 pix_data = gen((b >> 1) % 4, i);
      end
      if (edge_sel) @(negedge pix_clk); else @(posedge pix_clk);
      #3 mon_on = 1'b0; enable = 1'b0;
      chk("R6 R8 frames received", 32'(rd_idx + 2 >= wr_idx), 32'd1);
      // R5: data presented while disabled must not appear
      pix_data = 28'hFFFFFFF;
      repeat (6) @(negedge bit_clk);
      for (int k = 0; k < 20; k++) begin
         @(negedge bit_clk);
         chk("R5 disabled lanes low", 32'({lane_dout, lane_clk}), 32'd0);
         if (k == 10) pix_data = 28'h0F0F0F0;
      end
   endtask

   initial begin
      repeat (4) @(negedge bit_clk);
      chk("R7 reset outputs low", 32'({lane_dout, lane_clk}), 32'd0);
      rst_n = 1'b1;
      repeat (20) @(negedge bit_clk);
      chk("R7 idle outputs low", 32'({lane_dout, lane_clk}), 32'd0);
      for (int b = 0; b < 8; b++) run_burst(b);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #200000;
      nchk++; nfail++;
      $display("FAIL watchdog R6 act=%0d exp=%0d", rd_idx, wr_idx);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule